// File: doc/BRIEF.md
# Two-Wire Serial Command Slave

This block is the bus-facing front end of a dual digital potentiometer. It sits on a two-wire serial bus as a slave and runs on a fast system clock. It finds start and stop conditions on the bus and accepts an eight-bit address made of a fixed type nibble and four strap pins. It then takes an instruction byte and, for some commands, a data byte. It answers reads by shifting data out, and it acknowledges by pulling the data line low through an open-drain output.

Each accepted instruction is turned into a one-cycle strobe. The strobe carries a 4-bit operation code, a pot select, a register select and, for writes, a six-bit value. A register bank and a pair of wiper counters outside this block consume the strobe. The block also has an open-ended stepping mode, in which each SCL pulse moves the selected wiper one tap. A busy input from the nonvolatile store makes the slave ignore its own address, so a master can poll for completion.

Top module: `twowire_cmd_slave`

## Requirements
- R1: During and right after a synchronous reset, `sda_drive_low`, `op_strobe` and `step_pulse` are all 0.
- R2: The slave acknowledges an address byte only if its upper nibble is 0101 and its lower nibble equals `dev_addr` (MSB first on the bus). Any other address gets no acknowledge, and the rest of the transfer is ignored until the next start.
- R3: While `nv_busy` is 1, a matching address gets no acknowledge. Once `nv_busy` returns to 0, the same address is acknowledged again.
- R4: The instruction byte is laid out as opcode[7:4], a zero at bit 3, pot select at bit 2 and register select at bits 1:0. The four transfer opcodes are 1101, 1110, 0001 and 1000. For each of them, exactly one `op_strobe` pulse is raised at the SCL fall that ends the instruction acknowledge. While the strobe is high, `op_code`, `op_pot` and `op_reg` hold the received fields.
- R5: The write opcodes 1010 (wiper) and 1100 (data register) take a third byte and acknowledge it. They then raise one `op_strobe` with `op_wdata` equal to bits 5:0 of that byte.
- R6: The read opcodes 1001 and 1011 raise no strobe. After the instruction acknowledge, the slave shifts out {00, `rd_data`} MSB first over eight SCL clocks. It then releases SDA for the master's acknowledge bit and stays silent until a stop or a start.
- R7: Opcode 0010 enters stepping mode. Each later complete SCL pulse gives one `step_pulse`, issued when SCL falls. `step_up` is 1 if SDA was high at the SCL rise and 0 if SDA was low. A stop or a start ends the mode, and an SCL pulse that a stop or start interrupts gives no step.
- R8: An opcode outside the nine defined ones is acknowledged but causes neither a strobe nor a step.
- R9: A start in the middle of any transfer drops the partial byte and restarts address reception.
- R10: The slave starts pulling SDA low only while synchronised SCL is low, and `op_strobe` and `step_pulse` are single-cycle pulses raised while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_drive_low | output | 1 | 1 pulls the data line low; 0 releases it |
| dev_addr | input | 4 | Strap pins for the low address nibble |
| nv_busy | input | 1 | Nonvolatile write in progress |
| rd_data | input | 6 | Read value from the bank for the latched op/pot/reg |
| op_strobe | output | 1 | One-cycle command strobe |
| op_code | output | 4 | Latched opcode |
| op_pot | output | 1 | Latched pot select |
| op_reg | output | 2 | Latched register select |
| op_wdata | output | 6 | Latched write value |
| step_pulse | output | 1 | One-cycle wiper step request |
| step_up | output | 1 | Step direction, 1 toward the high end |

## Verification
The assertions check three rules on every cycle. The slave only begins an SDA pull-down while SCL is low. Command strobes and step pulses last one cycle, arise while SCL is low, and never coincide. Whether a given address, opcode or busy state produces an acknowledge, a strobe with the right fields, the right read bits or the right number and direction of steps depends on whole bus transactions. Only the bench's scenarios can show those.

// File: rtl/twc_pkg.sv
// Shared constants and types for the two-wire command slave.
// Assumes an 8-bit bus byte and a 4-bit opcode field.
package twc_pkg;
    localparam int          BYTE_W  = 8;
    localparam int          CNT_W   = 4;
    localparam logic [3:0]  TYPE_ID = 4'b0101;

    localparam logic [3:0] OP_RD_WIPER = 4'b1001;
    localparam logic [3:0] OP_WR_WIPER = 4'b1010;
    localparam logic [3:0] OP_RD_REG   = 4'b1011;
    localparam logic [3:0] OP_WR_REG   = 4'b1100;
    localparam logic [3:0] OP_LOAD_ONE = 4'b1101;
    localparam logic [3:0] OP_SAVE_ONE = 4'b1110;
    localparam logic [3:0] OP_LOAD_ALL = 4'b0001;
    localparam logic [3:0] OP_SAVE_ALL = 4'b1000;
    localparam logic [3:0] OP_STEP     = 4'b0010;

    typedef enum logic [1:0] {
        K_NONE, K_XFER, K_WRITE, K_READ
    } op_kind_t;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_AACK, S_INSTR, S_IACK, S_DRX,
        S_DACK, S_DTX, S_MACK, S_STEP, S_WAIT
    } state_t;
endpackage

// File: rtl/twc_sync.sv
// Synchroniser and edge finder for the bus lines.
// Each line passes through STAGES flops that reset to the idle-high level.
// One more flop gives the previous sample, so edges are one cycle wide.
module twc_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            logic              prev;
            // shift the raw line through the chain and keep the last sample
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '1;
                    prev  <= 1'b1;
                end else begin
                    chain <= {chain[STAGES-2:0], raw[g]};
                    prev  <= chain[STAGES-1];
                end
            end
            assign lvl[g]  = chain[STAGES-1];
            assign rise[g] = chain[STAGES-1] & ~prev;
            assign fall[g] = ~chain[STAGES-1] & prev;
        end
    endgenerate
endmodule

// File: rtl/twc_op_decode.sv
// Sorts a 4-bit opcode into the bus form it needs.
// Stepping and unknown codes both map to K_NONE. The caller tells them apart.
module twc_op_decode
    import twc_pkg::*;
(
    input  logic [3:0] op,
    output op_kind_t   kind
);
    // table lookup from opcode to command form
    always_comb begin
        case (op)
            OP_LOAD_ONE, OP_SAVE_ONE,
            OP_LOAD_ALL, OP_SAVE_ALL: kind = K_XFER;
            OP_WR_WIPER, OP_WR_REG:   kind = K_WRITE;
            OP_RD_WIPER, OP_RD_REG:   kind = K_READ;
            default:                  kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/twowire_cmd_slave.sv
// Two-wire bus slave that decodes potentiometer commands into strobes.
// Assumes clk runs at least 16x SCL. Bus lines are sampled through twc_sync.
// The caller must supply rd_data combinationally from op_code/op_pot/op_reg.
module twowire_cmd_slave
    import twc_pkg::*;
#(
    parameter int DATA_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low,
    input  logic [3:0]        dev_addr,
    input  logic              nv_busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic              op_strobe,
    output logic [3:0]        op_code,
    output logic              op_pot,
    output logic [1:0]        op_reg,
    output logic [DATA_W-1:0] op_wdata,
    output logic              step_pulse,
    output logic              step_up
);
    localparam int PAD_W = BYTE_W - DATA_W;

    logic [1:0] lvl, rise, fall;
    logic       scl_s, sda_s, scl_rise, scl_fall;
    logic       start_ev, stop_ev;

    twc_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({scl_i, sda_i}),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    assign scl_s    = lvl[1];
    assign sda_s    = lvl[0];
    assign scl_rise = rise[1];
    assign scl_fall = fall[1];
    assign start_ev = fall[0] & scl_s;
    assign stop_ev  = rise[0] & scl_s;

    op_kind_t kind;
    twc_op_decode u_dec (.op(op_code), .kind(kind));

    state_t            state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              step_pend, step_dir;

    // bus protocol engine: start/stop override, then per-state bit handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= S_IDLE;
            bit_cnt       <= '0;
            rx_sh         <= '0;
            tx_sh         <= '0;
            sda_drive_low <= 1'b0;
            op_strobe     <= 1'b0;
            op_code       <= '0;
            op_pot        <= 1'b0;
            op_reg        <= '0;
            op_wdata      <= '0;
            step_pulse    <= 1'b0;
            step_up       <= 1'b0;
            step_pend     <= 1'b0;
            step_dir      <= 1'b0;
        end else begin
            op_strobe  <= 1'b0;
            step_pulse <= 1'b0;
            if (start_ev) begin
                state         <= S_ADDR;
                bit_cnt       <= '0;
                sda_drive_low <= 1'b0;
                step_pend     <= 1'b0;
            end else if (stop_ev) begin
                state         <= S_IDLE;
                sda_drive_low <= 1'b0;
                step_pend     <= 1'b0;
            end else begin
                case (state)
                    S_ADDR, S_INSTR, S_DRX: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
                            bit_cnt <= '0;
                            if (state == S_ADDR) begin
                                if (rx_sh == {TYPE_ID, dev_addr} && !nv_busy) begin
                                    sda_drive_low <= 1'b1;
                                    state         <= S_AACK;
                                end else begin
                                    state <= S_WAIT;
                                end
                            end else if (state == S_INSTR) begin
                                op_code       <= rx_sh[7:4];
                                op_pot        <= rx_sh[2];
                                op_reg        <= rx_sh[1:0];
                                sda_drive_low <= 1'b1;
                                state         <= S_IACK;
                            end else begin
                                op_wdata      <= rx_sh[DATA_W-1:0];
                                sda_drive_low <= 1'b1;
                                state         <= S_DACK;
                            end
                        end
                    end
                    S_AACK: if (scl_fall) begin
                        sda_drive_low <= 1'b0;
                        state         <= S_INSTR;
                    end
                    S_IACK: if (scl_fall) begin
                        sda_drive_low <= 1'b0;
                        case (kind)
                            K_XFER: begin
                                op_strobe <= 1'b1;
                                state     <= S_WAIT;
                            end
                            K_WRITE: state <= S_DRX;
                            K_READ: begin
                                tx_sh         <= {{PAD_W{1'b0}}, rd_data};
                                sda_drive_low <= ~rd_data[DATA_W-1] | (PAD_W > 0);
                                state         <= S_DTX;
                            end
                            default: state <= (op_code == OP_STEP) ? S_STEP : S_WAIT;
                        endcase
                    end
                    S_DACK: if (scl_fall) begin
                        sda_drive_low <= 1'b0;
                        op_strobe     <= 1'b1;
                        state         <= S_WAIT;
                    end
                    S_DTX: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
                        if (scl_fall) begin
                            if (bit_cnt == CNT_W'(BYTE_W)) begin
                                sda_drive_low <= 1'b0;
                                state         <= S_MACK;
                            end else begin
                                tx_sh         <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_drive_low <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    S_MACK: if (scl_fall) state <= S_WAIT;
                    S_STEP: begin
                        if (scl_rise) begin
                            step_pend <= 1'b1;
                            step_dir  <= sda_s;
                        end
                        if (scl_fall && step_pend) begin
                            step_pulse <= 1'b1;
                            step_up    <= step_dir;
                            step_pend  <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/twc_chk.sv
// Protocol checker for twowire_cmd_slave, bound to every instance.
// Looks at the synchronised SCL level inside the slave.
module twc_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_drive_low,
    input logic op_strobe,
    input logic step_pulse
);
    // R10: a pull-down only begins while SCL is low
    p_pull_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !$past(scl_s));

    // R4: a command strobe lasts one cycle
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_strobe |=> !op_strobe);

    // R7: a step request lasts one cycle
    p_step_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |=> !step_pulse);

    // R10: strobes appear at an SCL fall, so SCL was low
    p_strobe_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_strobe) |-> !$past(scl_s));

    // R7: steps appear at an SCL fall, so SCL was low
    p_step_on_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_pulse) |-> !$past(scl_s));

    // R8: a strobe and a step never coincide
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_strobe && step_pulse));
endmodule

bind twowire_cmd_slave twc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s),
    .sda_drive_low(sda_drive_low), .op_strobe(op_strobe), .step_pulse(step_pulse)
);

// File: tb/tb_twowire_cmd_slave.sv
module tb_twowire_cmd_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int NV         = 10;
    localparam logic [3:0] PINS = 4'b1011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       sda_drive_low, nv_busy = 1'b0;
    logic [5:0] rd_data = '0;
    logic       op_strobe, op_pot, step_pulse, step_up;
    logic [3:0] op_code;
    logic [1:0] op_reg;
    logic [5:0] op_wdata;
    wire        bus_sda = m_sda & ~sda_drive_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    twowire_cmd_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .sda_drive_low(sda_drive_low), .dev_addr(PINS), .nv_busy(nv_busy),
        .rd_data(rd_data), .op_strobe(op_strobe), .op_code(op_code),
        .op_pot(op_pot), .op_reg(op_reg), .op_wdata(op_wdata),
        .step_pulse(step_pulse), .step_up(step_up)
    );

    int n_tests = 0, n_fail = 0;
    int n_strobe = 0, n_step = 0, n_up = 0;
    logic [3:0] c_code; logic c_pot; logic [1:0] c_reg; logic [5:0] c_wdata;

    // monitor away from the active edge
    always @(negedge clk) begin
        if (op_strobe) begin
            n_strobe++; c_code = op_code; c_pot = op_pot; c_reg = op_reg; c_wdata = op_wdata;
        end
        if (step_pulse) begin n_step++; if (step_up) n_up++; end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wq(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic clk_bit(input logic v, output logic seen);
        m_sda = v; wq(Q); m_scl = 1'b1; wq(Q); seen = bus_sda; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
        clk_bit(1'b1, s);   // master no-acknowledge
    endtask

    function automatic int kind_of(input logic [3:0] op);
        case (op)
            4'b1101, 4'b1110, 4'b0001, 4'b1000: return 1;
            4'b1010, 4'b1100: return 2;
            4'b1001, 4'b1011: return 3;
            default: return 0;
        endcase
    endfunction

    // {instruction byte, data byte, read value}
    localparam logic [21:0] VEC [NV] = '{
        {8'b1101_0_1_10, 8'h00, 6'h00},
        {8'b1110_0_0_01, 8'h00, 6'h00},
        {8'b0001_0_0_11, 8'h00, 6'h00},
        {8'b1000_0_1_00, 8'h00, 6'h00},
        {8'b1010_0_1_00, 8'h2A, 6'h00},
        {8'b1100_0_0_11, 8'hFF, 6'h00},
        {8'b1001_0_0_00, 8'h00, 6'h15},
        {8'b1011_0_1_01, 8'h00, 6'h3E},
        {8'b0101_0_0_00, 8'h00, 6'h00},
        {8'b0000_0_1_10, 8'h00, 6'h00}
    };

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic ack; logic [7:0] rb; int s0, t0, u0;
        wq(5);
        check("R1 drive", sda_drive_low, 0);
        check("R1 strobe", op_strobe, 0);
        check("R1 step", step_pulse, 0);
        rst_n = 1'b1; wq(5);
        check("R1 drive after", sda_drive_low, 0);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] ins, dat; logic [5:0] rv; int k;
            ins = VEC[v][21:14]; dat = VEC[v][13:6]; rv = VEC[v][5:0];
            k = kind_of(ins[7:4]); rd_data = rv;
            s0 = n_strobe; t0 = n_step;
            bus_start();
            send_byte({4'b0101, PINS}, ack); check("R2 addr ack", ack, 1);
            send_byte(ins, ack);             check("R8 instr ack", ack, 1);
            if (k == 2) begin
                send_byte(dat, ack);         check("R5 data ack", ack, 1);
            end
            if (k == 3) begin
                recv_byte(rb);               check("R6 read byte", rb, {2'b00, rv});
                check("R6 released", sda_drive_low, 0);
            end
            bus_stop();
            if (k == 1 || k == 2) begin
                check("R4 strobe count", n_strobe - s0, 1);
                check("R4 op_code", c_code, ins[7:4]);
                check("R4 op_pot", c_pot, ins[2]);
                check("R4 op_reg", c_reg, ins[1:0]);
                if (k == 2) check("R5 wdata", c_wdata, dat[5:0]);
            end else begin
                check("R8 no strobe", n_strobe - s0, 0);
                check("R8 no step", n_step - t0, 0);
            end
        end

        // R2: wrong pins, then wrong type nibble
        s0 = n_strobe;
        bus_start(); send_byte({4'b0101, PINS ^ 4'b0001}, ack); check("R2 pin mismatch", ack, 0);
        send_byte(8'b1101_0_0_00, ack); check("R2 ignored after", ack, 0);
        bus_stop();
        bus_start(); send_byte({4'b0110, PINS}, ack); check("R2 type mismatch", ack, 0);
        bus_stop();
        check("R2 no strobe", n_strobe - s0, 0);

        // R3: busy silences the address, then acknowledge returns
        nv_busy = 1'b1;
        bus_start(); send_byte({4'b0101, PINS}, ack); check("R3 busy no ack", ack, 0); bus_stop();
        nv_busy = 1'b0;
        bus_start(); send_byte({4'b0101, PINS}, ack); check("R3 ack after busy", ack, 1); bus_stop();

        // R7: stepping, three up and one down, stop pulse not counted
        t0 = n_step; u0 = n_up;
        bus_start(); send_byte({4'b0101, PINS}, ack);
        send_byte(8'b0010_0_1_00, ack); check("R7 step ack", ack, 1);
        clk_bit(1'b1, ack); clk_bit(1'b1, ack); clk_bit(1'b0, ack); clk_bit(1'b1, ack);
        bus_stop();
        check("R7 step count", n_step - t0, 4);
        check("R7 up count", n_up - u0, 3);
        check("R7 pot latched", op_pot, 1);
        bus_start(); clk_bit(1'b1, ack); bus_stop();
        check("R7 mode ended", n_step - t0, 4);

        // R9: restart in the middle of an instruction byte
        s0 = n_strobe;
        bus_start(); send_byte({4'b0101, PINS}, ack);
        clk_bit(1'b1, ack); clk_bit(1'b1, ack); clk_bit(1'b0, ack);
        m_sda = 1'b1; wq(Q);
        bus_start(); send_byte({4'b0101, PINS}, ack); check("R9 readdress ack", ack, 1);
        send_byte(8'b1110_0_1_11, ack); bus_stop();
        check("R9 one strobe", n_strobe - s0, 1);
        check("R9 op_code", c_code, 4'b1110);
        check("R9 op_reg", c_reg, 3);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule